// File: doc/BRIEF.md
# Ethernet Transmit Frame Finisher

This block sits in the transmit path between a packet source and a MAC transmitter. Both sides are byte-wide streams with valid, ready and last signals. Each frame arrives complete, with its 14-byte header in front: destination address, source address, then type/length. The block forwards the frame unchanged. Two sideband flags come with the closing byte: one asks for a CRC-32 frame check sequence, the other asks for short frames to be padded.

When padding is requested, zero bytes are added until the frame reaches the 64-byte minimum. That minimum counts the check sequence when one follows. So with both flags set the data is filled to 60 bytes, and the four check bytes make 64. While pad or check bytes go out, the input is held off. The block marks the final emitted byte, reports the frame's total emitted length on that byte, and flags input frames longer than 1536 bytes. Such frames are still forwarded in full.

Top module: `eth_tx_finish`

## Requirements
- R1: During and after reset, `out_valid` is low until a byte is offered, no frame is in progress, and `in_ready` follows `out_ready`. A frame cut short by reset leaves no trace on the next frame.
- R2: Input bytes pass through unchanged and in order. While input bytes are forwarded, `out_valid` follows `in_valid` and `in_ready` follows `out_ready`. `in_ready` is never high while `out_ready` is low, and a stalled output byte stays stable.
- R3: With `in_pad_en`=1 and `in_fcs_en`=0, a frame shorter than 64 bytes is extended with 0x00 bytes to exactly 64 bytes.
- R4: With both flags at 1, a frame shorter than 60 bytes is extended with 0x00 bytes to 60 bytes, and the 4 check bytes follow, for 64 in total.
- R5: With `in_fcs_en`=1, four bytes follow the last data or pad byte. They are the complement of a CRC-32 computed over every preceding byte of the frame, padding included. The CRC uses the reflected polynomial 0x04C11DB7 with the register preset to all ones. The value is sent least significant byte first. For the 9-byte frame "123456789" the appended bytes are 0x26, 0x39, 0xF4, 0xCB.
- R6: With `in_fcs_en`=0 no byte is appended. With `in_pad_en`=0 a short frame is not extended.
- R7: The two flags are read only on the byte that carries `in_last`. Their values on any other byte have no effect.
- R8: `in_ready` is low from the cycle after the closing input byte is accepted until the final emitted byte is accepted. `out_last` is high on the final emitted byte and on no other.
- R9: On the final emitted byte, `out_len` equals the total number of bytes emitted for the frame.
- R10: `out_oversize` is high on the final emitted byte of a frame whose input exceeded 1536 bytes. It is low on every other byte, and frames are never truncated.
- R11: With padding requested, a frame already at its minimum is not extended. That minimum is 60 data bytes when a check sequence follows and 64 bytes when none does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with `in_valid` |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Closing byte of the input frame |
| in_pad_en | input | 1 | Pad short frame; read with `in_last` |
| in_fcs_en | input | 1 | Append check sequence; read with `in_last` |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Output byte taken when high with `out_valid` |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the emitted frame |
| out_len | output | CW (16) | Emitted byte count, valid with `out_last` |
| out_oversize | output | 1 | Input frame exceeded the maximum length, valid with `out_last` |

## Verification
The stall-stability property assumes the source follows stream rules: once it offers a byte it keeps `in_valid`, `in_data` and `in_last` steady until that byte is accepted. The bench driver changes the input only after an accepted handshake. The check on `in_ready` and the length check both assume frames shorter than the counter's range, and every frame in the stimulus stays well below it. The flags are driven to the opposite of their intended value on every non-closing byte, so any early sampling shows up in the emitted bytes.

// File: rtl/eth_tx_finish.sv
module eth_tx_finish #(
  parameter int MIN_FRAME = 64,
  parameter int MAX_FRAME = 1536,
  parameter int CW        = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  input  logic          in_pad_en,
  input  logic          in_fcs_en,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          out_last,
  output logic [CW-1:0] out_len,
  output logic          out_oversize
);
  localparam logic [CW-1:0] MIN_ALL  = CW'(MIN_FRAME);
  localparam logic [CW-1:0] MIN_DATA = CW'(MIN_FRAME - 4);
  localparam logic [CW-1:0] MAX_LEN  = CW'(MAX_FRAME);
  localparam logic [31:0]   POLY_R   = 32'hEDB88320;

  typedef enum logic [1:0] {S_PASS, S_PAD, S_FCS} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [31:0]   crc;
  logic          fcs_r, ovf_r;
  logic [1:0]    fidx;

  function automatic logic [31:0] crc_upd(logic [31:0] c, logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int b = 0; b < 8; b++)
      r = r[0] ? ((r >> 1) ^ POLY_R) : (r >> 1);
    return r;
  endfunction

  logic [CW-1:0] cnt_inc, tgt_in, tgt_r;
  logic          need_pad, big, pad_done, out_hs;
  logic [31:0]   fcs_val;

  assign cnt_inc  = cnt + 1'b1;
  assign tgt_in   = in_fcs_en ? MIN_DATA : MIN_ALL;
  assign tgt_r    = fcs_r ? MIN_DATA : MIN_ALL;
  assign need_pad = in_pad_en && (cnt_inc < tgt_in);
  assign big      = cnt_inc > MAX_LEN;
  assign pad_done = cnt_inc >= tgt_r;
  assign fcs_val  = ~crc;
  assign out_hs   = out_valid && out_ready;
  assign out_len  = cnt_inc;

  always_comb begin
    out_valid = 1'b1;
    in_ready  = 1'b0;
    out_data  = 8'h00;
    out_last  = 1'b0;
    case (st)
      S_PASS: begin
        out_valid = in_valid;
        in_ready  = out_ready;
        out_data  = in_data;
        out_last  = in_last && !need_pad && !in_fcs_en;
      end
      S_PAD:   out_last = pad_done && !fcs_r;
      S_FCS: begin
        out_data = fcs_val[8*fidx +: 8];
        out_last = (fidx == 2'd3);
      end
      default: out_valid = 1'b0;
    endcase
  end

  assign out_oversize = out_valid && out_last && ((st == S_PASS) ? big : ovf_r);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_PASS;
      cnt   <= '0;
      crc   <= '1;
      fcs_r <= 1'b0;
      ovf_r <= 1'b0;
      fidx  <= 2'd0;
    end else if (out_hs) begin
      if (out_last) begin
        st   <= S_PASS;
        cnt  <= '0;
        crc  <= '1;
        fidx <= 2'd0;
      end else begin
        cnt <= cnt_inc;
        case (st)
          S_PASS: begin
            crc <= crc_upd(crc, out_data);
            if (in_last) begin
              fcs_r <= in_fcs_en;
              ovf_r <= big;
              st    <= need_pad ? S_PAD : S_FCS;
            end
          end
          S_PAD: begin
            crc <= crc_upd(crc, out_data);
            if (pad_done) st <= S_FCS;
          end
          default: fidx <= fidx + 2'd1;
        endcase
      end
    end
  end
endmodule

// File: rtl/eth_tx_finish_chk.sv
module eth_tx_finish_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_last,
  input logic          out_valid,
  input logic          out_ready,
  input logic [7:0]    out_data,
  input logic          out_last,
  input logic [CW-1:0] out_len,
  input logic          out_oversize
);
  logic [CW-1:0] emitted;
  logic          tail;
  logic          o_hs, i_end;

  assign o_hs  = out_valid && out_ready;
  assign i_end = in_valid && in_ready && in_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      emitted <= '0;
      tail    <= 1'b0;
    end else begin
      if (o_hs) emitted <= out_last ? '0 : emitted + 1'b1;
      if (o_hs && out_last) tail <= 1'b0;
      else if (i_end)       tail <= 1'b1;
    end
  end

  // R2
  ready_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> out_ready);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R8
  tail_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tail |-> !in_ready);

  // R9
  len_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (out_len == emitted + 1'b1));

  // R10
  oversize_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_oversize |-> (out_valid && out_last));
endmodule

bind eth_tx_finish eth_tx_finish_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last), .out_len(out_len),
  .out_oversize(out_oversize)
);

// File: tb/eth_tx_finish_test.sv
module eth_tx_finish_test;
  localparam int CLK_NS = 10;
  localparam int NV = 12;
  localparam int BUF = 1600;
  // {len, pad, fcs, stall}
  localparam logic [18:0] VEC [0:NV-1] = '{
    {16'd20, 1'b1, 1'b1, 1'b0}, {16'd20, 1'b1, 1'b0, 1'b1},
    {16'd20, 1'b0, 1'b1, 1'b0}, {16'd20, 1'b0, 1'b0, 1'b1},
    {16'd59, 1'b1, 1'b1, 1'b1}, {16'd60, 1'b1, 1'b1, 1'b0},
    {16'd63, 1'b1, 1'b0, 1'b0}, {16'd64, 1'b1, 1'b0, 1'b1},
    {16'd100, 1'b1, 1'b1, 1'b1}, {16'd1, 1'b1, 1'b1, 1'b0},
    {16'd1536, 1'b0, 1'b0, 1'b0}, {16'd1537, 1'b0, 1'b1, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, in_pad_en = 1'b0, in_fcs_en = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic out_ready = 1'b1;
  logic in_ready, out_valid, out_last, out_oversize;
  logic [7:0] out_data;
  logic [15:0] out_len;

  eth_tx_finish uut (.*);

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic stall = 1'b0;
  logic [7:0] src [0:BUF-1];
  logic [7:0] exp [0:BUF-1];
  logic [7:0] got [0:BUF-1];
  int got_n = 0, n_last = 0, last_pos = 0, bad_ovf = 0, viol = 0;
  int got_len = 0;
  logic got_ovf = 1'b0, done = 1'b0, tail = 1'b0;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic chk(bit ok, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    fails++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    summary();
  end

  always @(posedge clk) begin
    #1;
    cyc++;
    out_ready = !(stall && (cyc % 3 == 0));
  end

  always @(negedge clk) begin
    if (tail && in_ready) viol++;
    if (out_valid && out_ready) begin
      got[got_n] = out_data;
      got_n++;
      if (out_oversize && !out_last) bad_ovf++;
      if (out_last) begin
        n_last++;
        last_pos = got_n;
        got_len = int'(out_len);
        got_ovf = out_oversize;
        done = 1'b1;
      end
    end
    if (in_valid && in_ready && in_last && !(out_valid && out_ready && out_last)) tail = 1'b1;
    if (out_valid && out_ready && out_last) tail = 1'b0;
  end

  function automatic logic [31:0] ref_crc(int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ exp[i][b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB8_8320;
      end
    return ~c;
  endfunction

  task automatic send(int len, bit pad, bit fcs);
    for (int i = 0; i < len; i++) begin
      bit hs = 0;
      in_valid  = 1'b1;
      in_data   = src[i];
      in_last   = (i == len - 1);
      in_pad_en = in_last ? pad : !pad;
      in_fcs_en = in_last ? fcs : !fcs;
      while (!hs) begin
        @(negedge clk);
        hs = in_ready;
        @(posedge clk);
        #1;
      end
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic run(int len, bit pad, bit fcs, bit stl, string tag);
    int n = len;
    int mism = 0;
    logic [31:0] c;
    stall = stl;
    got_n = 0; n_last = 0; last_pos = 0; bad_ovf = 0; viol = 0; done = 1'b0; tail = 1'b0;
    for (int i = 0; i < len; i++) exp[i] = src[i];
    if (pad) while (n < (fcs ? 60 : 64)) begin exp[n] = 8'h00; n++; end
    if (fcs) begin
      c = ref_crc(n);
      for (int k = 0; k < 4; k++) begin exp[n] = c[8*k +: 8]; n++; end
    end
    send(len, pad, fcs);
    while (!done) @(posedge clk);
    #1;
    stall = 1'b0;
    for (int i = 0; i < n && i < got_n; i++) if (got[i] !== exp[i]) mism++;
    chk(got_n == n, {tag, " R6 R11 emitted count"}, got_n, n);
    chk(mism == 0, {tag, " R2 R7 byte mismatches"}, mism, 0);
    chk(got_len == n, {tag, " R9 reported length"}, got_len, n);
    chk(got_ovf == (len > 1536) && bad_ovf == 0, {tag, " R10 oversize flag"}, got_ovf, len > 1536);
    chk(n_last == 1 && last_pos == n, {tag, " R8 last position"}, last_pos, n);
    chk(viol == 0, {tag, " R8 in_ready during tail"}, viol, 0);
  endtask

  initial begin
    string tag;
    int len;
    bit pad, fcs;
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 idle after reset", {out_valid, in_ready}, 1);
    @(posedge clk); #1;

    for (int v = 0; v < NV; v++) begin
      len = int'(VEC[v][18:3]);
      pad = VEC[v][2];
      fcs = VEC[v][1];
      for (int i = 0; i < len; i++) src[i] = 8'((i * 7) + (v * 13) + 1);
      if (pad && fcs) tag = "R4 R5";
      else if (pad) tag = "R3";
      else if (fcs) tag = "R5 R6";
      else tag = "R6";
      if (pad && len >= (fcs ? 60 : 64)) tag = {tag, " R11"};
      tag = $sformatf("vec%0d %s", v, tag);
      run(len, pad, fcs, VEC[v][0], tag);
    end

    for (int i = 0; i < 9; i++) src[i] = 8'h31 + 8'(i);
    run(9, 1'b0, 1'b1, 1'b0, "known R5");
    chk({got[9], got[10], got[11], got[12]} == 32'h2639F4CB, "R5 known check bytes",
        {got[9], got[10], got[11], got[12]}, 32'h2639F4CB);

    for (int i = 0; i < 5; i++) begin
      in_valid = 1'b1; in_data = 8'hA5; in_last = 1'b0;
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 mid-frame reset clears output", out_valid, 0);
    @(posedge clk); #1;
    for (int i = 0; i < 30; i++) src[i] = 8'(i * 3 + 5);
    run(30, 1'b1, 1'b1, 1'b1, "after reset R1 R4");

    summary();
  end
endmodule